// File: doc/BRIEF.md
# RTC Seconds Prescaler with Calibration Period Counter

This block turns a 32.768 kHz timebase into a one-second tick for a real-time clock. A binary ripple-free divider of `DIV_BITS` stages (15 by default, which makes a ratio of 32768) runs on the reference clock and emits a single-cycle `tick_o` once per full wrap. A control bit can park the whole divider at zero. While it is set the divider cannot advance, so software can release it at a known instant and align the seconds phase.

A second counter, `CAL_W` bits wide (17 by default), counts those ticks while it is enabled. Each time it has reached the programmed limit it restarts from zero and raises `cal_pulse_o` for one cycle. A later correction stage uses this pulse to add or drop a second. Clearing the enable parks the counter at zero.

Software reaches the block through a plain write port with two locations. Location 0 holds the control bits: bit 0 parks the divider and bit 1 enables calibration. Location 1 holds the limit. Nothing inside the block can be read back.

Top module: `rtc_tick_gen`

## Requirements
- R1: With the park bit 0, `tick_o` is high for exactly one cycle every 2^`DIV_BITS` cycles. The first tick comes 2^`DIV_BITS` clock edges after the edge that released the divider.
- R2: While the park bit (location 0, bit 0) reads 1, no tick is produced and all divider stages stay at zero. After the bit is cleared, the first tick comes exactly 2^`DIV_BITS` cycles after the write edge.
- R3: Writing location 0 with the park bit 0 while the divider runs leaves the tick phase unchanged. The next tick still comes 2^`DIV_BITS` cycles after the previous one.
- R4: With the calibration enable (location 0, bit 1) at 0, `cal_pulse_o` stays low whatever limit is programmed, and the counter is held at zero.
- R5: With the enable at 1 and a limit L > 0 (location 1), `cal_pulse_o` fires on every (L+1)-th tick counted from the enable, repeating indefinitely.
- R6: `cal_pulse_o` is a one-cycle pulse. It is raised in the cycle directly after the `tick_o` cycle that completed the period.
- R7: A limit of 0 holds the calibration counter at zero, and no pulse is raised.
- R8: Clearing the enable restarts the count. After it is set again, a full L+1 ticks pass before the next pulse.
- R9: A synchronous active-high `rst` clears the divider, the calibration counter, both control bits and the limit. Both outputs are low on the first cycle after reset.
- R10: If the limit is lowered below the current count, the next tick counts as reaching the limit. That tick ends the period with a pulse instead of running the counter round its full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control bits, 1 = calibration limit |
| wr_data | input | CAL_W | Write data; control uses bit 0 (park) and bit 1 (calibration enable) |
| tick_o | output | 1 | One-cycle seconds tick |
| cal_pulse_o | output | 1 | One-cycle calibration period pulse |

## Verification
The hardest case to reach from the ports is the calibration counter sitting above a newly written limit. The counter value is not visible, so the bench builds it from known history. It enables calibration with a large limit, counts four ticks at the port and then writes a smaller limit. It then checks that the very next tick closes the period. The restart after a disable is reached the same way: the bench counts part of a period, toggles the enable, and confirms that a full period follows. The bench builds the block with a short divider so that many seconds fit in the run.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
    localparam logic SEL_CTRL  = 1'b0;
    localparam logic SEL_LIMIT = 1'b1;
    localparam int   BIT_PARK  = 0;
    localparam int   BIT_CALEN = 1;

    typedef struct packed {
        logic cal_en;
        logic park;
    } ctrl_t;
endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_tick_pkg::*;
#(
    parameter int CAL_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CAL_W-1:0] wr_data,
    output ctrl_t            ctrl_o,
    output logic [CAL_W-1:0] limit_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CAL_W-1:0] limit;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_sel == SEL_CTRL) begin
                regs_d.ctrl.park   = wr_data[BIT_PARK];
                regs_d.ctrl.cal_en = wr_data[BIT_CALEN];
            end else begin
                regs_d.limit = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign ctrl_o  = regs_q.ctrl;
    assign limit_o = regs_q.limit;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic park_i,
    output logic tick_o
);
    localparam logic [DIV_BITS-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic [DIV_BITS-1:0] cnt;
        logic                tick;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (park_i) begin
            div_d.cnt  = '0;
            div_d.tick = 1'b0;
        end else begin
            div_d.cnt  = div_q.cnt + 1'b1;
            div_d.tick = (div_q.cnt == CNT_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end

    assign tick_o = div_q.tick;
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter #(
    parameter int CAL_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CAL_W-1:0] limit_i,
    output logic             pulse_o
);
    typedef struct packed {
        logic [CAL_W-1:0] cnt;
        logic             pulse;
    } cal_t;

    cal_t cal_d, cal_q;

    always_comb begin
        cal_d       = cal_q;
        cal_d.pulse = 1'b0;
        if (!en_i) begin
            cal_d.cnt = '0;
        end else if (tick_i) begin
            if (limit_i == '0) begin
                cal_d.cnt = '0;
            end else if (cal_q.cnt >= limit_i) begin
                cal_d.cnt   = '0;
                cal_d.pulse = 1'b1;
            end else begin
                cal_d.cnt = cal_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cal_q <= '0;
        else     cal_q <= cal_d;
    end

    assign pulse_o = cal_q.pulse;
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
    import rtc_tick_pkg::*;
#(
    parameter int DIV_BITS = 15,
    parameter int CAL_W    = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CAL_W-1:0] wr_data,
    output logic             tick_o,
    output logic             cal_pulse_o
);
    ctrl_t            ctrl_q;
    logic [CAL_W-1:0] limit_q;

    rtc_ctrl_regs #(.CAL_W(CAL_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_o  (ctrl_q),
        .limit_o (limit_q)
    );

    rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_div (
        .clk    (clk),
        .rst    (rst),
        .park_i (ctrl_q.park),
        .tick_o (tick_o)
    );

    rtc_cal_counter #(.CAL_W(CAL_W)) u_cal (
        .clk     (clk),
        .rst     (rst),
        .en_i    (ctrl_q.cal_en),
        .tick_i  (tick_o),
        .limit_i (limit_q),
        .pulse_o (cal_pulse_o)
    );
endmodule

// File: rtl/rtc_tick_gen_chk.sv
module rtc_tick_gen_chk #(
    parameter int CAL_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             pulse,
    input logic             park,
    input logic             cal_en,
    input logic [CAL_W-1:0] limit
);
    // R1: a tick never lasts more than one cycle
    assert_tick_single_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R2: a divider parked for two cycles emits nothing
    assert_park_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (park && $past(park)) |-> !tick);

    // R4: calibration disabled over two cycles emits nothing
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!cal_en && !$past(cal_en)) |-> !pulse);

    // R6: a period pulse follows a tick and is one cycle wide
    assert_pulse_after_tick_R6: assert property (@(posedge clk) disable iff (rst)
        pulse |-> ($past(tick) && !tick));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R7: a zero limit held over two cycles gives no pulse
    assert_zero_limit_R7: assert property (@(posedge clk) disable iff (rst)
        (limit == '0 && $past(limit) == '0) |-> !pulse);

    // R9: the cycle after reset shows cleared outputs and controls
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tick && !pulse && !park && !cal_en && limit == '0));
endmodule

bind rtc_tick_gen rtc_tick_gen_chk #(.CAL_W(CAL_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_o),
    .pulse  (cal_pulse_o),
    .park   (ctrl_q.park),
    .cal_en (ctrl_q.cal_en),
    .limit  (limit_q)
);

// File: tb/rtc_tick_gen_bench.sv
module rtc_tick_gen_bench;
    localparam int DIV_BITS = 5;
    localparam int CAL_W    = 17;
    localparam int PERIOD   = 1 << DIV_BITS;
    localparam int NVEC     = 4;
    localparam int LIM_TAB [NVEC] = '{1, 2, 3, 6};
    localparam int TICK_TAB[NVEC] = '{2, 3, 4, 7};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic             wr_sel = 1'b0;
    logic [CAL_W-1:0] wr_data = '0;
    logic             tick_o, cal_pulse_o;
    int               cyc = 0;
    int               n_run = 0, n_fail = 0;
    bit               done = 1'b0;

    rtc_tick_gen #(.DIV_BITS(DIV_BITS), .CAL_W(CAL_W)) u_rtc_tick_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick_o(tick_o), .cal_pulse_o(cal_pulse_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = CAL_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick(output int at);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!tick_o && guard < 4 * PERIOD);
        at = cyc;
    endtask

    // counts ticks from the current negedge until a pulse; also checks pulse follows a tick
    task automatic ticks_to_pulse(output int ticks, output bit follows);
        bit prev = 1'b0;
        int guard = 0;
        ticks = 0; follows = 1'b0;
        forever begin
            if (cal_pulse_o) begin
                follows = prev;
                break;
            end
            if (tick_o) ticks++;
            prev = tick_o;
            if (guard > 40 * PERIOD) begin ticks = -1; break; end
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic run_ticks(input int n, output int pulses);
        int k = 0;
        pulses = 0;
        forever begin
            if (tick_o) k++;
            if (cal_pulse_o) pulses++;
            if (k >= n) break;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, n, p;
        bit f;

        do_reset();
        t0 = cyc;
        @(negedge clk);
        check(!tick_o && !cal_pulse_o, "R9 outputs low after reset", tick_o + cal_pulse_o, 0);

        wait_tick(t1);
        check(t1 - t0 == PERIOD, "R1 first tick latency", t1 - t0, PERIOD);
        wait_tick(t2);
        check(t2 - t1 == PERIOD, "R1 tick period", t2 - t1, PERIOD);

        // R2: park the divider
        wr(1'b0, 1);
        n = 0;
        repeat (3 * PERIOD) begin
            @(negedge clk);
            if (tick_o) n++;
        end
        check(n == 0, "R2 no tick while parked", n, 0);
        wr(1'b0, 0);
        t0 = cyc;
        wait_tick(t1);
        check(t1 - t0 == PERIOD, "R2 release latency", t1 - t0, PERIOD);

        // R3: a control write with park 0 leaves the phase alone
        repeat (10) @(negedge clk);
        wr(1'b0, 0);
        wait_tick(t2);
        check(t2 - t1 == PERIOD, "R3 phase kept", t2 - t1, PERIOD);

        // R4: disabled calibration with a nonzero limit
        wr(1'b1, 1);
        run_ticks(5, p);
        check(p == 0, "R4 no pulse when disabled", p, 0);

        // R7: zero limit, enabled
        wr(1'b1, 0);
        wr(1'b0, 2);
        run_ticks(5, p);
        check(p == 0, "R7 no pulse with zero limit", p, 0);

        // R5/R6: table walk
        for (int i = 0; i < NVEC; i++) begin
            wr(1'b0, 0);
            wr(1'b1, LIM_TAB[i]);
            wr(1'b0, 2);
            ticks_to_pulse(n, f);
            check(n == TICK_TAB[i], "R5 first period", n, TICK_TAB[i]);
            check(f, "R6 pulse follows tick", int'(f), 1);
            @(negedge clk);
            check(!cal_pulse_o, "R6 pulse one cycle", int'(cal_pulse_o), 0);
            ticks_to_pulse(n, f);
            check(n == TICK_TAB[i], "R5 repeat period", n, TICK_TAB[i]);
            @(negedge clk);
        end

        // R8: disable part way through restarts the count
        wr(1'b0, 0);
        wr(1'b1, 3);
        wr(1'b0, 2);
        run_ticks(2, p);
        wr(1'b0, 0);
        wr(1'b0, 2);
        ticks_to_pulse(n, f);
        check(n == 4, "R8 full period after re-enable", n, 4);
        @(negedge clk);

        // R10: lowering the limit below the count
        wr(1'b0, 0);
        wr(1'b1, 5);
        wr(1'b0, 2);
        run_ticks(4, p);
        wr(1'b1, 2);
        ticks_to_pulse(n, f);
        check(n == 1, "R10 lowered limit ends period", n, 1);
        @(negedge clk);

        // R9: reset clears controls that were set
        wr(1'b1, 1);
        wr(1'b0, 3);
        do_reset();
        t0 = cyc;
        wait_tick(t1);
        check(t1 - t0 == PERIOD, "R9 park cleared by reset", t1 - t0, PERIOD);
        run_ticks(4, p);
        check(p == 0, "R9 calibration cleared by reset", p, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule